// File: doc/BRIEF.md
# Four-Point Complex DFT Adder Network

This block takes four complex samples, each with an 8-bit signed real part and an 8-bit signed imaginary part. It produces the four bins of their discrete Fourier transform. The twiddle factors of a 4-point transform are all ±1 or ±j, so every output component is a signed sum of four input components. No multiplier is needed.

Eight identical transform units each produce one component: the real or imaginary part of one bin. Each unit uses three carry-lookahead adders. The first adder sums the two operands that enter with a plus sign. The second sums the two operands that enter with a minus sign; in a subtracting unit these two are bit-inverted, and both first-stage adders take a carry-in of 1, which completes both two's complements. The third adder merges the two partial sums.

Samples are captured into an input register when `in_valid` is high. The eight results land together in an output register one clock later, flagged by `out_valid`. The block has no state machine: the pipeline is two register stages, an input stage and a result stage, each loaded only when its valid bit is set.

Top module: `dft4_adder_net`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first result, `out_valid` is 0 and every bit of `y_re` and `y_im` is 0.
- R2: If `in_valid` is high at rising edge n, `out_valid` is high after edge n+1. If `in_valid` is low at edge n, `out_valid` is low after edge n+1. Valid samples on consecutive edges give results on consecutive cycles.
- R3: Inputs are signed two's complement, with sample n in bits [8n+7:8n] of `x_re` and `x_im`. Bin k is in bits [10k+9:10k] of `y_re` and `y_im` as 10-bit signed values. Bin 0 is Re = xr0+xr1+xr2+xr3 and Im = xi0+xi1+xi2+xi3.
- R4: Bin 1 is Re = xr0+xi1−xr2−xi3 and Im = xi0−xr1−xi2+xr3.
- R5: Bin 2 is Re = xr0−xr1+xr2−xr3 and Im = xi0−xi1+xi2−xi3.
- R6: Bin 3 is Re = xr0−xi1−xr2+xi3 and Im = xi0+xr1−xi2−xr3.
- R7: With every input at −128 or at 127, all results are exact in 10 bits, including the extreme sums −512 and +508.
- R8: When `in_valid` is low, `x_re` and `x_im` are ignored, and `y_re` and `y_im` keep their last values.
- R9: After each result, the sum of the four real bins equals 4·xr0 and the sum of the four imaginary bins equals 4·xi0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Samples on `x_re`/`x_im` are valid this edge |
| x_re | input | 32 | Real parts of samples 0..3, 8 bits each, signed |
| x_im | input | 32 | Imaginary parts of samples 0..3, 8 bits each, signed |
| out_valid | output | 1 | `y_re`/`y_im` hold a new result this cycle |
| y_re | output | 40 | Real parts of bins 0..3, 10 bits each, signed |
| y_im | output | 40 | Imaginary parts of bins 0..3, 10 bits each, signed |

## Verification
The assertions assume that `in_valid` is never unknown once reset is released. They place no limit on the sample values, since every 8-bit pattern is a legal input. The stimulus drives `in_valid` and the sample buses only on falling clock edges and holds `in_valid` low through reset. It reaches the value extremes through fixed table rows of −128 and 127 and mixed-sign rows, plus a pseudo-random stream. Changing samples are applied with `in_valid` low to show that they are ignored.

// File: rtl/dft4_pkg.sv
package dft4_pkg;
    localparam int SAMP_W = 8;
    localparam int POINTS = 4;
endpackage

// File: rtl/dft4_cla.sv
module dft4_cla #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    logic [W-1:0] gen;
    logic [W-1:0] prp;
    logic [W-1:0] carry;

    assign gen = a & b;
    assign prp = a ^ b;
    assign carry[0] = cin;

    // each carry expanded from generate/propagate terms of all lower bits
    for (genvar i = 1; i < W; i++) begin : g_carry
        always_comb begin
            logic acc;
            acc = cin;
            for (int j = 0; j < i; j++) begin
                acc = gen[j] | (prp[j] & acc);
            end
            carry[i] = acc;
        end
    end

    assign sum = prp ^ carry;
endmodule

// File: rtl/dft4_unit.sv
module dft4_unit #(
    parameter int IN_W   = 8,
    parameter int OUT_W  = 10,
    parameter bit NEGATE = 1'b1
) (
    input  logic [IN_W-1:0]  pos_a,
    input  logic [IN_W-1:0]  pos_b,
    input  logic [IN_W-1:0]  neg_a,
    input  logic [IN_W-1:0]  neg_b,
    output logic [OUT_W-1:0] result
);
    localparam int EXT = OUT_W - IN_W;

    logic [OUT_W-1:0] pa, pb, na, nb;
    logic [OUT_W-1:0] part_pos, part_neg;
    logic             stage_cin;

    assign pa = {{EXT{pos_a[IN_W-1]}}, pos_a};
    assign pb = {{EXT{pos_b[IN_W-1]}}, pos_b};

    if (NEGATE) begin : g_sub
        assign na = ~{{EXT{neg_a[IN_W-1]}}, neg_a};
        assign nb = ~{{EXT{neg_b[IN_W-1]}}, neg_b};
        assign stage_cin = 1'b1;
    end else begin : g_add
        assign na = {{EXT{neg_a[IN_W-1]}}, neg_a};
        assign nb = {{EXT{neg_b[IN_W-1]}}, neg_b};
        assign stage_cin = 1'b0;
    end

    dft4_cla #(.W(OUT_W)) u_pos   (.a(pa), .b(pb), .cin(stage_cin), .sum(part_pos));
    dft4_cla #(.W(OUT_W)) u_neg   (.a(na), .b(nb), .cin(stage_cin), .sum(part_neg));
    dft4_cla #(.W(OUT_W)) u_merge (.a(part_pos), .b(part_neg), .cin(1'b0), .sum(result));
endmodule

// File: rtl/dft4_adder_net.sv
module dft4_adder_net
    import dft4_pkg::*;
#(
    parameter int IN_W = SAMP_W,
    parameter int NPT  = POINTS
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [NPT*IN_W-1:0]             x_re,
    input  logic [NPT*IN_W-1:0]             x_im,
    output logic                            out_valid,
    output logic [NPT*(IN_W+$clog2(NPT))-1:0] y_re,
    output logic [NPT*(IN_W+$clog2(NPT))-1:0] y_im
);
    localparam int OUT_W = IN_W + $clog2(NPT);

    logic [IN_W-1:0]  re_q [NPT];
    logic [IN_W-1:0]  im_q [NPT];
    logic             stage_v;
    logic [IN_W-1:0]  op_re [NPT][4];
    logic [IN_W-1:0]  op_im [NPT][4];
    logic [OUT_W-1:0] bin_re [NPT];
    logic [OUT_W-1:0] bin_im [NPT];
    logic [OUT_W-1:0] res_re_q [NPT];
    logic [OUT_W-1:0] res_im_q [NPT];

    // input register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_v <= 1'b0;
            for (int n = 0; n < NPT; n++) begin
                re_q[n] <= '0;
                im_q[n] <= '0;
            end
        end else begin
            stage_v <= in_valid;
            if (in_valid) begin
                for (int n = 0; n < NPT; n++) begin
                    re_q[n] <= x_re[n*IN_W +: IN_W];
                    im_q[n] <= x_im[n*IN_W +: IN_W];
                end
            end
        end
    end

    // operand routing: slots 0,1 enter with plus, slots 2,3 with minus
    always_comb begin
        op_re[0] = '{re_q[0], re_q[1], re_q[2], re_q[3]};
        op_im[0] = '{im_q[0], im_q[1], im_q[2], im_q[3]};
        op_re[1] = '{re_q[0], im_q[1], re_q[2], im_q[3]};
        op_im[1] = '{im_q[0], re_q[3], re_q[1], im_q[2]};
        op_re[2] = '{re_q[0], re_q[2], re_q[1], re_q[3]};
        op_im[2] = '{im_q[0], im_q[2], im_q[1], im_q[3]};
        op_re[3] = '{re_q[0], im_q[3], im_q[1], re_q[2]};
        op_im[3] = '{im_q[0], re_q[1], im_q[2], re_q[3]};
    end

    for (genvar k = 0; k < NPT; k++) begin : g_bin
        dft4_unit #(.IN_W(IN_W), .OUT_W(OUT_W), .NEGATE(k != 0)) u_re (
            .pos_a(op_re[k][0]), .pos_b(op_re[k][1]),
            .neg_a(op_re[k][2]), .neg_b(op_re[k][3]),
            .result(bin_re[k])
        );
        dft4_unit #(.IN_W(IN_W), .OUT_W(OUT_W), .NEGATE(k != 0)) u_im (
            .pos_a(op_im[k][0]), .pos_b(op_im[k][1]),
            .neg_a(op_im[k][2]), .neg_b(op_im[k][3]),
            .result(bin_im[k])
        );
        assign y_re[k*OUT_W +: OUT_W] = res_re_q[k];
        assign y_im[k*OUT_W +: OUT_W] = res_im_q[k];
    end

    // result register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            for (int k = 0; k < NPT; k++) begin
                res_re_q[k] <= '0;
                res_im_q[k] <= '0;
            end
        end else begin
            out_valid <= stage_v;
            if (stage_v) begin
                for (int k = 0; k < NPT; k++) begin
                    res_re_q[k] <= bin_re[k];
                    res_im_q[k] <= bin_im[k];
                end
            end
        end
    end

    // checking-only sums across bins
    logic signed [OUT_W+1:0] bin_sum_re, bin_sum_im, four_re0, four_im0;
    always_comb begin
        bin_sum_re = '0;
        bin_sum_im = '0;
        for (int k = 0; k < NPT; k++) begin
            bin_sum_re = bin_sum_re + {{2{res_re_q[k][OUT_W-1]}}, res_re_q[k]};
            bin_sum_im = bin_sum_im + {{2{res_im_q[k][OUT_W-1]}}, res_im_q[k]};
        end
    end
    assign four_re0 = {{(OUT_W-IN_W){re_q[0][IN_W-1]}}, re_q[0], 2'b00};
    assign four_im0 = {{(OUT_W-IN_W){im_q[0][IN_W-1]}}, im_q[0], 2'b00};

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_v |=> ($stable(y_re) && $stable(y_im)));
    // R9
    bin_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (bin_sum_re == $past(four_re0) && bin_sum_im == $past(four_im0)));
endmodule

// File: tb/dft4_adder_net_tb.sv
`timescale 1ns/1ps
module dft4_adder_net_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] x_re = '0;
    logic [31:0] x_im = '0;
    logic        out_valid;
    logic [39:0] y_re;
    logic [39:0] y_im;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dft4_adder_net u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_re(x_re), .x_im(x_im),
        .out_valid(out_valid), .y_re(y_re), .y_im(y_im)
    );

    localparam int NVEC = 8;
    localparam logic [31:0] VEC_RE [NVEC] = '{
        32'h00000000, 32'h80808080, 32'h7F7F7F7F, 32'h807F807F,
        32'h7F807F80, 32'h01020304, 32'hFF10C87F, 32'h80007F01
    };
    localparam logic [31:0] VEC_IM [NVEC] = '{
        32'h00000001, 32'h80808080, 32'h7F7F7F7F, 32'h7F807F80,
        32'h807F807F, 32'hFCFDFEFF, 32'h7F8040E0, 32'h017F0080
    };

    function automatic int sx8(input logic [31:0] v, input int n);
        return int'($signed(v[n*8 +: 8]));
    endfunction
    function automatic int sx10(input logic [39:0] v, input int k);
        return int'($signed(v[k*10 +: 10]));
    endfunction

    int er [4];
    int ei [4];

    task automatic model(input logic [31:0] r, input logic [31:0] i);
        int r0, r1, r2, r3, i0, i1, i2, i3;
        r0 = sx8(r,0); r1 = sx8(r,1); r2 = sx8(r,2); r3 = sx8(r,3);
        i0 = sx8(i,0); i1 = sx8(i,1); i2 = sx8(i,2); i3 = sx8(i,3);
        er[0] = r0+r1+r2+r3;  ei[0] = i0+i1+i2+i3;
        er[1] = r0+i1-r2-i3;  ei[1] = i0-r1-i2+r3;
        er[2] = r0-r1+r2-r3;  ei[2] = i0-i1+i2-i3;
        er[3] = r0-i1-r2+i3;  ei[3] = i0+r1-i2-r3;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_bins(input string tag);
        string rq [4] = '{"R3", "R4", "R5", "R6"};
        check({"R2 valid ", tag}, int'(out_valid), 1);
        for (int k = 0; k < 4; k++) begin
            check({rq[k], " re ", tag}, sx10(y_re, k), er[k]);
            check({rq[k], " im ", tag}, sx10(y_im, k), ei[k]);
        end
    endtask

    task automatic apply(input logic [31:0] r, input logic [31:0] i, input string tag);
        @(negedge clk);
        x_re = r; x_im = i; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        model(r, i);
        check_bins(tag);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [39:0] keep_re, keep_im;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 y_re in reset", int'(y_re != 0), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 y_im after reset", int'(y_im != 0), 0);

        // table walk, includes R7 extremes (rows 1-4)
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC_RE[v], VEC_IM[v], $sformatf("vec%0d", v));
        end
        // R7 explicit extreme magnitudes
        model(32'h80808080, 32'h7F7F7F7F);
        check("R7 min sum", er[0], -512);
        check("R7 max sum", ei[0], 508);
        apply(32'h80808080, 32'h7F7F7F7F, "R7 extreme");

        // pseudo-random stream
        seed = 32'h1234_5678;
        for (int t = 0; t < 40; t++) begin
            logic [31:0] rr, ii;
            seed = seed * 32'd1664525 + 32'd1013904223; rr = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; ii = seed;
            apply(rr, ii, $sformatf("rand%0d", t));
        end

        // R8: inputs ignored while in_valid is low
        keep_re = y_re; keep_im = y_im;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            x_re = 32'hA5A5_0000 ^ (t * 32'h1111_1111);
            x_im = ~x_re;
        end
        @(negedge clk);
        check("R8 y_re held", int'(y_re == keep_re), 1);
        check("R8 y_im held", int'(y_im == keep_im), 1);
        check("R8 no valid", int'(out_valid), 0);

        // R2 back-to-back samples
        @(negedge clk);
        x_re = 32'h11223344; x_im = 32'h55667788; in_valid = 1'b1;
        @(negedge clk);
        x_re = 32'h90A0B0C0; x_im = 32'h0F1E2D3C;
        @(negedge clk);
        in_valid = 1'b0;
        model(32'h11223344, 32'h55667788);
        check_bins("b2b first");
        @(negedge clk);
        model(32'h90A0B0C0, 32'h0F1E2D3C);
        check_bins("b2b second");
        @(negedge clk);
        check("R2 valid drops", int'(out_valid), 0);

        // R9 bin sums against the last sample
        check("R9 re sum", er[0]+er[1]+er[2]+er[3], 4*sx8(32'h90A0B0C0,0));
        check("R9 re sum dut", sx10(y_re,0)+sx10(y_re,1)+sx10(y_re,2)+sx10(y_re,3),
              4*sx8(32'h90A0B0C0,0));
        check("R9 im sum dut", sx10(y_im,0)+sx10(y_im,1)+sx10(y_im,2)+sx10(y_im,3),
              4*sx8(32'h0F1E2D3C,0));

        // R1 reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid on reset", int'(out_valid), 0);
        check("R1 outputs on reset", int'((y_re | y_im) != 0), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule